// File: doc/BRIEF.md
# Hardwired Ring-Counter Control Sequencer

This block is the control unit of a small accumulator processor. A six-position ring counter walks through timing steps T1 to T6. In each step the block decodes the current step and the 4-bit opcode from the instruction register into a 12-bit control word. That word enables every register load and every bus driver in the datapath. The datapath itself (program counter, address register, RAM, instruction register, accumulator, operand register, adder/subtractor and output register) sits outside the block.

The first three steps fetch the next instruction and are the same for every opcode. Steps T4 to T6 carry out the instruction. Any step that an instruction does not use leaves every control line low. A halt opcode freezes the ring and raises `halt`. Only a reset clears that state.

Top module: `ring_seq_ctrl`

## Requirements
- R1: While `rst` (synchronous, active high) is high, `ctrl` is all zero and `halt` is low. The first cycle after `rst` falls is step T1.
- R2: Control word bit positions are: 0 program-counter increment, 1 program counter drives bus, 2 address register load, 3 RAM drives bus, 4 instruction register load, 5 instruction address field drives bus, 6 accumulator load, 7 accumulator drives bus, 8 subtract select, 9 adder result drives bus, 10 operand register load, 11 output register load.
- R3: Fetch is the same for every opcode. T1 gives `ctrl`=0x006, T2 gives 0x001 and T3 gives 0x018.
- R4: Load opcode 4'b0000 gives 0x024 at T4, 0x048 at T5 and 0x000 at T6.
- R5: Add opcode 4'b0001 gives 0x024 at T4, 0x408 at T5 and 0x240 at T6.
- R6: Subtract opcode 4'b0010 gives 0x024 at T4, 0x408 at T5 and 0x340 at T6. The subtract line (bit 8) is never high for any other opcode.
- R7: Output opcode 4'b1110 gives 0x880 at T4 and 0x000 at T5 and T6.
- R8: Outside halt the ring advances one step per clock. T6 is followed by T1, so each instruction takes exactly six cycles.
- R9: Halt opcode 4'b1111 gives `ctrl`=0 at T4 and raises `halt` in that cycle. From then on `halt` stays high, `ctrl` stays zero and the opcode input is ignored until reset.
- R10: Any other opcode leaves T4 to T6 with `ctrl`=0. The sequence then continues with the next fetch.
- R11: In every cycle at most one of the bus-drive lines (bits 1, 3, 5, 7, 9) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field from the instruction register |
| ctrl | output | 12 | Control word, bit layout per R2 |
| halt | output | 1 | High once a halt instruction reaches T4 |

## Verification
The control word and `halt` are decoded combinationally from the ring register. Each result therefore belongs to the cycle in which its step is current and can be read one time unit after the falling edge that starts that cycle. Every clock edge moves the ring by exactly one step, or zero steps once halted. The bench changes inputs only on falling edges, checks just after them, and then advances exactly one clock per step. In this way each of the six expected words in a row lines up with its own T-step. After halt, several further cycles confirm that the outputs stay frozen while the opcode changes.

// File: rtl/ring_seq_ctrl.sv
module ring_seq_ctrl #(
  parameter int OPW   = 4,
  parameter int CW    = 12,
  parameter int STEPS = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [CW-1:0]  ctrl,
  output logic           halt
);
  localparam logic [OPW-1:0] OP_LOAD = 4'b0000;
  localparam logic [OPW-1:0] OP_ADD  = 4'b0001;
  localparam logic [OPW-1:0] OP_SUB  = 4'b0010;
  localparam logic [OPW-1:0] OP_OUT  = 4'b1110;
  localparam logic [OPW-1:0] OP_STOP = 4'b1111;

  localparam int PC_INC = 0, PC_DRV = 1, AR_LD = 2, MEM_DRV = 3, IR_LD = 4, IRA_DRV = 5,
                 ACC_LD = 6, ACC_DRV = 7, SUB_SEL = 8, ALU_DRV = 9, OPB_LD = 10, OUT_LD = 11;
  localparam logic [CW-1:0] DRV_MASK = CW'((1 << PC_DRV) | (1 << MEM_DRV) | (1 << IRA_DRV) |
                                           (1 << ACC_DRV) | (1 << ALU_DRV));

  logic [STEPS-1:0] step;
  logic             halted_q;
  logic             stop_now;
  logic [CW-1:0]    word;

  assign stop_now = step[3] && (opcode == OP_STOP);
  assign halt     = !rst && (halted_q || stop_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= STEPS'(1);
      halted_q <= 1'b0;
    end else begin
      halted_q <= halted_q | stop_now;
      if (!halt) step <= {step[STEPS-2:0], step[STEPS-1]};
    end
  end

  always_comb begin
    word = '0;
    if (step[0]) begin
      word[PC_DRV] = 1'b1;
      word[AR_LD]  = 1'b1;
    end
    if (step[1]) word[PC_INC] = 1'b1;
    if (step[2]) begin
      word[MEM_DRV] = 1'b1;
      word[IR_LD]   = 1'b1;
    end
    if (step[3]) begin
      if (opcode == OP_LOAD || opcode == OP_ADD || opcode == OP_SUB) begin
        word[IRA_DRV] = 1'b1;
        word[AR_LD]   = 1'b1;
      end else if (opcode == OP_OUT) begin
        word[ACC_DRV] = 1'b1;
        word[OUT_LD]  = 1'b1;
      end
    end
    if (step[4]) begin
      if (opcode == OP_LOAD) begin
        word[MEM_DRV] = 1'b1;
        word[ACC_LD]  = 1'b1;
      end else if (opcode == OP_ADD || opcode == OP_SUB) begin
        word[MEM_DRV] = 1'b1;
        word[OPB_LD]  = 1'b1;
      end
    end
    if (step[5] && (opcode == OP_ADD || opcode == OP_SUB)) begin
      word[ALU_DRV] = 1'b1;
      word[ACC_LD]  = 1'b1;
      word[SUB_SEL] = (opcode == OP_SUB);
    end
  end

  assign ctrl = (rst || halt) ? '0 : word;

  assert_ring_onehot_R8: assert property (@(posedge clk) disable iff (rst) $onehot(step));
  assert_ring_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!halt && step[STEPS-1]) |=> step[0]);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst) halt |=> halt);
  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(step));
  assert_sub_only_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl[SUB_SEL] |-> (opcode == OP_SUB));
  assert_one_driver_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl & DRV_MASK));
endmodule

// File: tb/test_ring_seq_ctrl.sv
module test_ring_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'b0000;
  logic [11:0] ctrl;
  logic        halt;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  ring_seq_ctrl i_ring_seq_ctrl (.clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl), .halt(halt));

  always #10 clk = ~clk;

  localparam logic [11:0] FETCH [0:2] = '{12'h006, 12'h001, 12'h018};
  localparam logic [3:0]  OPS   [0:5] = '{4'b0000, 4'b0001, 4'b0010, 4'b1110, 4'b0101, 4'b1001};
  localparam logic [11:0] EXEC  [0:5][0:2] = '{
    '{12'h024, 12'h048, 12'h000},
    '{12'h024, 12'h408, 12'h240},
    '{12'h024, 12'h408, 12'h340},
    '{12'h880, 12'h000, 12'h000},
    '{12'h000, 12'h000, 12'h000},
    '{12'h000, 12'h000, 12'h000}};
  localparam string TAG [0:5] = '{"R4", "R5", "R6", "R7", "R10", "R10"};
  localparam logic [11:0] DRV = 12'h2AA;

  task automatic chk(input logic [11:0] exp_c, input logic exp_h, input string tag);
    #1;
    checks++;
    if (ctrl !== exp_c || halt !== exp_h) begin
      errors++;
      $display("FAIL %s: ctrl=%h halt=%b expected ctrl=%h halt=%b", tag, ctrl, halt, exp_c, exp_h);
    end
    if ($countones(ctrl & DRV) > 1) begin
      errors++;
      $display("FAIL R11: ctrl=%h drivers=%0d expected at most 1", ctrl, $countones(ctrl & DRV));
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: ran=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(12'h000, 1'b0, "R1 during reset");
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      opcode = OPS[i];
      for (int t = 0; t < 3; t++)
        chk(FETCH[t], 1'b0, (t == 0) ? "R8/R3 fetch T1" : "R3/R2 fetch");
      for (int t = 0; t < 3; t++) chk(EXEC[i][t], 1'b0, TAG[i]);
    end
    opcode = 4'b1111;
    for (int t = 0; t < 3; t++) chk(FETCH[t], 1'b0, "R3 fetch before stop");
    chk(12'h000, 1'b1, "R9 stop at T4");
    for (int k = 0; k < 8; k++) begin
      opcode = (k % 2 == 0) ? 4'b0001 : 4'b1110;
      chk(12'h000, 1'b1, "R9 halted, opcode ignored");
    end
    rst = 1'b1;
    @(negedge clk);
    chk(12'h000, 1'b0, "R1 reset clears halt");
    rst = 1'b0;
    opcode = 4'b0010;
    chk(12'h006, 1'b0, "R1 first step T1 after reset");
    chk(12'h001, 1'b0, "R8 T2 after reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule